// File: doc/BRIEF.md
# Lane-Split Signed Saturating Adder

This block adds or subtracts two 32-bit words that can be treated as one signed 32-bit value, two signed 16-bit values, or four signed 8-bit values. The word is built from four 8-bit slices. A lane-mode input decides where the carry chain is cut, so each lane computes on its own. When saturation is enabled for an operation, any lane whose true result falls outside its signed range is pinned to that lane's largest or smallest value. When saturation is off, the lane wraps.

Each operation is presented with a valid strobe and its result appears, packed in the same lane layout, one clock later. A sticky status bit records that some lane was clamped at any point since it was last cleared. Only an explicit clear input resets it. Because every step clamps on its own, chained saturating operations do not associate. For example, (64 + 70) - 25 in an 8-bit lane yields 102, while 64 + (70 - 25) yields 109.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_mode` selects the lane layout: 0 gives one 32-bit lane, 1 gives two 16-bit lanes (bits 15:0 and 31:16), 2 gives four 8-bit lanes (byte k at bits 8k+7:8k). The value 3 behaves exactly like 2.
- R2: No carry or borrow passes from one lane into the next, in either add or subtract.
- R3: With `sat_en` high, each lane whose exact signed result exceeds its maximum returns the maximum (0x7F / 0x7FFF / 0x7FFFFFFF). Each lane whose exact result is below its minimum returns the minimum (0x80 / 0x8000 / 0x80000000). Each lane decides this independently.
- R4: With `sat_en` low, every lane returns its exact result modulo 2 to the power of the lane width.
- R5: `sub_en` high computes `op_a - op_b` per lane. Low computes `op_a + op_b`.
- R6: `out_valid` and `result` reflect an operation one clock after it is sampled with `in_valid` high. In a cycle after `in_valid` was low, `out_valid` is low and `result` keeps its previous value.
- R7: `sat_flag` goes high one clock after a valid operation in which `sat_en` was high and at least one lane clamped. It then stays high until cleared. Wrapping operations never set it.
- R8: `sat_clr` high clears `sat_flag` at the next clock edge. If a clamping operation is sampled in the same cycle, the flag is set instead.
- R9: While `rst` is high, `out_valid`, `result` and `sat_flag` are driven to zero at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_a | input | 32 | First packed operand |
| op_b | input | 32 | Second packed operand |
| lane_mode | input | 2 | Lane layout select (0: 1x32, 1: 2x16, 2 or 3: 4x8) |
| sub_en | input | 1 | 1 = subtract, 0 = add |
| sat_en | input | 1 | 1 = clamp per lane, 0 = wrap |
| sat_clr | input | 1 | Clear the sticky clamp flag |
| out_valid | output | 1 | Result register holds a fresh operation |
| result | output | 32 | Packed per-lane results |
| sat_flag | output | 1 | Sticky: a lane has clamped since last clear |

## Verification
The hardest case to reach from the ports is a single operation in which neighbouring lanes clamp in opposite directions while the carry or borrow out of a lower lane would, if not cut, flip the sign of the lane above. Directed operands place all-ones and sign-boundary patterns on both sides of each cut point. The same operands run in every lane mode, and these cases are mixed with a chained pair that shows non-associativity. A long stream of random operands, modes, operations and clear pulses is then compared against a per-lane model written with wide integers. That stream also checks the clear-versus-set collision on the sticky flag.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

    localparam int SLICE_W    = 8;
    localparam int NUM_SLICES = 4;
    localparam int DATA_W     = SLICE_W * NUM_SLICES;
    localparam int MODE_W     = 2;
    localparam int MODE_MAX   = $clog2(NUM_SLICES);
    localparam int IDX_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;

    typedef enum logic [MODE_W-1:0] {
        LANES_WIDE   = 2'd0,
        LANES_HALF   = 2'd1,
        LANES_NARROW = 2'd2,
        LANES_ALIAS  = 2'd3
    } lane_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              clamped;
    } lane_result_t;

    // Number of slices that make up one lane in the given mode.
    function automatic int unsigned slices_per_lane(lane_mode_e m);
        int unsigned sh;
        sh = (int'(m) > MODE_MAX) ? MODE_MAX : int'(m);
        return NUM_SLICES >> sh;
    endfunction

endpackage

// File: rtl/simd_slice.sv
module simd_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf,
    output logic         pos_dir
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff   = b ^ {W{invert}};
        full    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        sum     = full[W-1:0];
        cout    = full[W];
        // Signed overflow if this slice holds a lane's sign bit.
        ovf     = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        // On overflow the exact result shares the sign of a.
        pos_dir = ~a[W-1];
    end
endmodule

// File: rtl/simd_lane_ctrl.sv
module simd_lane_ctrl
    import simd_sat_pkg::*;
#(
    parameter int NS = NUM_SLICES,
    parameter int IW = IDX_W
) (
    input  lane_mode_e           mode,
    output logic [NS-1:0]        lane_start,
    output logic [NS-1:0]        lane_last,
    output logic [NS-1:0][IW-1:0] last_idx
);
    int unsigned grp;

    always_comb begin
        grp = slices_per_lane(mode);
        for (int k = 0; k < NS; k++) begin
            lane_start[k] = ((k % grp) == 0);
            lane_last[k]  = ((k % grp) == grp - 1);
            last_idx[k]   = IW'(k | (grp - 1));
        end
    end
endmodule

// File: rtl/simd_clamp.sv
module simd_clamp
    import simd_sat_pkg::*;
#(
    parameter int W  = SLICE_W,
    parameter int NS = NUM_SLICES,
    parameter int IW = IDX_W
) (
    input  logic [NS*W-1:0]        raw,
    input  logic [NS-1:0]          ovf,
    input  logic [NS-1:0]          pos_dir,
    input  logic [NS-1:0]          lane_last,
    input  logic [NS-1:0][IW-1:0]  last_idx,
    input  logic                   sat_en,
    output lane_result_t           res
);
    int e;

    always_comb begin
        res.data    = raw;
        res.clamped = sat_en && |(ovf & lane_last);
        for (int k = 0; k < NS; k++) begin
            e = int'(last_idx[k]);
            if (sat_en && ovf[e]) begin
                if (k == e)
                    res.data[k*W +: W] = pos_dir[e] ? {1'b0, {(W-1){1'b1}}}
                                                    : {1'b1, {(W-1){1'b0}}};
                else
                    res.data[k*W +: W] = {W{pos_dir[e]}};
            end
        end
    end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
    import simd_sat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [MODE_W-1:0] lane_mode,
    input  logic              sub_en,
    input  logic              sat_en,
    input  logic              sat_clr,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              sat_flag
);
    logic [NUM_SLICES-1:0]            lane_start;
    logic [NUM_SLICES-1:0]            lane_last;
    logic [NUM_SLICES-1:0][IDX_W-1:0] last_idx;
    logic [NUM_SLICES-1:0]            carry;
    logic [NUM_SLICES-1:0]            cin;
    logic [NUM_SLICES-1:0]            ovf;
    logic [NUM_SLICES-1:0]            pos_dir;
    logic [DATA_W-1:0]                raw;
    lane_result_t                     comb_res;

    simd_lane_ctrl #(.NS(NUM_SLICES), .IW(IDX_W)) u_ctrl (
        .mode       (lane_mode_e'(lane_mode)),
        .lane_start (lane_start),
        .lane_last  (lane_last),
        .last_idx   (last_idx)
    );

    genvar k;
    generate
        for (k = 0; k < NUM_SLICES; k++) begin : g_slice
            if (k == 0) begin : g_first
                assign cin[k] = sub_en;
            end else begin : g_rest
                // A lane boundary restarts the chain with the op's own carry-in.
                assign cin[k] = lane_start[k] ? sub_en : carry[k-1];
            end
            simd_slice #(.W(SLICE_W)) u_slice (
                .a       (op_a[k*SLICE_W +: SLICE_W]),
                .b       (op_b[k*SLICE_W +: SLICE_W]),
                .invert  (sub_en),
                .cin     (cin[k]),
                .sum     (raw[k*SLICE_W +: SLICE_W]),
                .cout    (carry[k]),
                .ovf     (ovf[k]),
                .pos_dir (pos_dir[k])
            );
        end
    endgenerate

    simd_clamp #(.W(SLICE_W), .NS(NUM_SLICES), .IW(IDX_W)) u_clamp (
        .raw       (raw),
        .ovf       (ovf),
        .pos_dir   (pos_dir),
        .lane_last (lane_last),
        .last_idx  (last_idx),
        .sat_en    (sat_en),
        .res       (comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            sat_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= comb_res.data;
            if (in_valid && comb_res.clamped)
                sat_flag <= 1'b1;
            else if (sat_clr)
                sat_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk
    import simd_sat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              sat_en,
    input logic              sat_clr,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              sat_flag
);
    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (!out_valid && !sat_flag && result == '0));

    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !sat_clr) |=> sat_flag);

    p_no_spurious_set_r7: assert property (@(posedge clk) disable iff (rst)
        (!sat_flag && !(in_valid && sat_en)) |=> !sat_flag);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (sat_clr && !in_valid) |=> !sat_flag);
endmodule

bind simd_sat_adder simd_sat_adder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .sat_en    (sat_en),
    .sat_clr   (sat_clr),
    .out_valid (out_valid),
    .result    (result),
    .sat_flag  (sat_flag)
);

// File: tb/sim_simd_sat_adder.sv
module sim_simd_sat_adder;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] op_a, op_b;
    logic [1:0]  lane_mode;
    logic        sub_en, sat_en, sat_clr;
    logic        out_valid;
    logic [31:0] result;
    logic        sat_flag;

    always #5 clk = ~clk;

    simd_sat_adder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .lane_mode(lane_mode), .sub_en(sub_en), .sat_en(sat_en), .sat_clr(sat_clr),
        .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
    );

    typedef struct {
        logic [31:0] res;
        logic        flag;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fails  = 0;
    logic        exp_flag = 1'b0;
    logic [31:0] last_res = '0;
    bit          done     = 0;

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-lane reference built from the requirements with wide integers.
    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                         input logic sub, input logic sat,
                         output logic [31:0] r, output logic clamp);
        int     eff, w, n;
        longint mask, maxv, minv, ai, bi, rr;
        eff  = (m > 2) ? 2 : int'(m);
        w    = 32 >> eff;
        n    = 32 / w;
        mask = (longint'(1) << w) - 1;
        maxv = (longint'(1) << (w - 1)) - 1;
        minv = -(longint'(1) << (w - 1));
        r    = '0;
        clamp = 1'b0;
        for (int l = 0; l < n; l++) begin
            ai = (longint'(a) >> (l * w)) & mask;
            bi = (longint'(b) >> (l * w)) & mask;
            if (ai > maxv) ai = ai - (mask + 1);
            if (bi > maxv) bi = bi - (mask + 1);
            rr = sub ? ai - bi : ai + bi;
            if (sat && rr > maxv) begin rr = maxv; clamp = 1'b1; end
            if (sat && rr < minv) begin rr = minv; clamp = 1'b1; end
            r = r | 32'((rr & mask) << (l * w));
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                         input logic sub, input logic sat, input logic clr, input string req);
        logic [31:0] r;
        logic        c;
        exp_t        item;
        @(negedge clk);
        in_valid  = 1'b1;
        op_a      = a;
        op_b      = b;
        lane_mode = m;
        sub_en    = sub;
        sat_en    = sat;
        sat_clr   = clr;
        model(a, b, m, sub, sat, r, c);
        if (c) exp_flag = 1'b1;
        else if (clr) exp_flag = 1'b0;
        item.res  = r;
        item.flag = exp_flag;
        item.req  = req;
        sb.push_back(item);
        last_res = r;
    endtask

    // One idle cycle, then check the registered state the cycle after.
    task automatic idle_check(input logic clr, input string req);
        @(negedge clk);
        in_valid = 1'b0;
        sat_clr  = clr;
        op_a     = 32'hDEAD_BEEF;
        op_b     = 32'h1357_9BDF;
        if (clr) exp_flag = 1'b0;
        @(negedge clk);
        check(req, "out_valid idle", {31'b0, out_valid}, 32'd0);
        check(req, "result held",    result,             last_res);
        check(req, "sat_flag",       {31'b0, sat_flag},  {31'b0, exp_flag});
        sat_clr = 1'b0;
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL R6 unexpected out_valid: actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "result",   result,            e.res);
                check(e.req, "sat_flag", {31'b0, sat_flag}, {31'b0, e.flag});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R6: actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; lane_mode = '0;
        sub_en = 1'b0; sat_en = 1'b0; sat_clr = 1'b0;
        repeat (3) @(negedge clk);
        // R9: state while in reset
        check("R9", "out_valid reset", {31'b0, out_valid}, 32'd0);
        check("R9", "result reset",    result,             32'd0);
        check("R9", "sat_flag reset",  {31'b0, sat_flag},  32'd0);
        rst = 1'b0;

        // R3: 8-bit lane clamps high and low
        drive(32'h0000_0040, 32'h0000_0045, 2'd2, 1'b0, 1'b1, 1'b0, "R3 64+69");
        idle_check(1'b0, "R7 sticky");
        idle_check(1'b1, "R8 clear");
        drive(32'h0000_0081, 32'h0000_0005, 2'd2, 1'b1, 1'b1, 1'b1, "R3 -127-5");
        // R3: chained saturation, (64+70)-25 = 102
        drive(32'h0000_0040, 32'h0000_0046, 2'd2, 1'b0, 1'b1, 1'b0, "R3 64+70");
        drive(32'h0000_007F, 32'h0000_0019, 2'd2, 1'b1, 1'b1, 1'b0, "R3 127-25");
        idle_check(1'b1, "R8 clear");
        check("R3", "chain 102", last_res, 32'h0000_0066);

        // R2: carries and borrows cut at lane boundaries
        drive(32'h00FF_00FF, 32'h0001_0001, 2'd2, 1'b0, 1'b0, 1'b0, "R2 b8 carry");
        drive(32'h00FF_00FF, 32'h0001_0001, 2'd1, 1'b0, 1'b0, 1'b0, "R2 h16 carry");
        drive(32'h00FF_00FF, 32'h0001_0001, 2'd0, 1'b0, 1'b0, 1'b0, "R2 w32 carry");
        drive(32'h0000_0000, 32'h0000_0001, 2'd2, 1'b1, 1'b0, 1'b0, "R2 b8 borrow");
        drive(32'h0000_0000, 32'h0000_0001, 2'd1, 1'b1, 1'b0, 1'b0, "R2 h16 borrow");
        drive(32'h0000_0000, 32'h0000_0001, 2'd0, 1'b1, 1'b0, 1'b0, "R2 w32 borrow");

        // R4: wrapping never sets the flag
        drive(32'h7F7F_7F7F, 32'h0101_0101, 2'd2, 1'b0, 1'b0, 1'b0, "R4 b8 wrap");
        drive(32'h7FFF_FFFF, 32'h0000_0001, 2'd0, 1'b0, 1'b0, 1'b0, "R4 w32 wrap");
        idle_check(1'b0, "R4 R7 no set");

        // R3: wide and mixed-direction clamps
        drive(32'h7FFF_FFFF, 32'h0000_0001, 2'd0, 1'b0, 1'b1, 1'b0, "R3 w32 max");
        drive(32'h8000_0000, 32'h0000_0001, 2'd0, 1'b1, 1'b1, 1'b0, "R3 w32 min");
        drive(32'h7FFF_8000, 32'h0001_FFFF, 2'd1, 1'b0, 1'b1, 1'b0, "R3 h16 mixed");
        drive(32'h7F80_10F0, 32'h0101_2010, 2'd2, 1'b0, 1'b1, 1'b1, "R3 R8 b8 mixed");

        // R5 and R1
        drive(32'h0A14_1E28, 32'h0102_0304, 2'd2, 1'b1, 1'b0, 1'b0, "R5 b8 sub");
        drive(32'h1234_5678, 32'h0FED_CBA9, 2'd1, 1'b1, 1'b1, 1'b0, "R5 h16 sub");
        drive(32'h80FF_7F01, 32'hFF01_0180, 2'd3, 1'b0, 1'b1, 1'b0, "R1 mode3");
        drive(32'h80FF_7F01, 32'hFF01_0180, 2'd2, 1'b0, 1'b1, 1'b0, "R1 mode2");
        idle_check(1'b0, "R6 hold");

        // Random stream across all features
        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra, rb;
            logic [3:0]  ctl;
            ra  = $urandom;
            rb  = $urandom;
            ctl = 4'($urandom);
            if (ctl[0]) ra[7:0] = 8'h7F;
            if (ctl[1]) rb[31:24] = 8'h80;
            drive(ra, rb, 2'($urandom), ctl[2], ctl[3] | ra[5],
                  ($urandom % 8) == 0, "R1/R2/R3/R4/R5/R8 random");
            if ((i % 50) == 49) idle_check(1'b0, "R6 R7 random idle");
        end
        idle_check(1'b0, "R6 drain");
        check("R6", "scoreboard empty", 32'(sb.size()), 32'd0);

        done = 1;
        report();
        $finish;
    end
endmodule